// File: doc/BRIEF.md
# Horizontal Line Interrupt Counter

This block raises a line interrupt once every N+1 displayed lines, where N is a reload value supplied by a control register. A line-timing generator tells it, through a one-cycle strobe, when horizontal blanking begins on each line. It also supplies the current line number and the number of the first line outside the visible area. That threshold changes with the 50/60 Hz frame mode, so the counting window follows whichever mode is in force.

The counter does nothing except on a strobe. On a strobe during the invisible part of the frame it reloads from the register. On a strobe during the visible part it counts down. When a strobe finds the count already at zero it fires instead of counting: it sets a pending flag and reloads. The pending flag stays set until the processor acknowledges it. The interrupt request output is the pending flag gated by an enable bit.

Top module: `line_irq_counter`

## Requirements
- R1: Reset clears the pending flag, the request and the count, so the first strobe on a visible line after reset fires at once.
- R2: With no strobe and no acknowledge, neither the pending flag nor the count changes.
- R3: A strobe whose line number is greater than or equal to the threshold reloads the count from the reload value and never fires. A line equal to the threshold counts as invisible.
- R4: A strobe on a visible line (line number below the threshold) with a nonzero count lowers the count by one and does not fire.
- R5: A strobe on a visible line with a zero count sets the pending flag and reloads the count in the same cycle, so consecutive interrupts are N+1 visible strobes apart.
- R6: The threshold is taken from the input on every strobe, so the same line number may be visible under one mode's threshold and invisible under another's.
- R7: The request output is high exactly when the pending flag is set and the enable input is high.
- R8: The pending flag stays set until an acknowledge cycle clears it, one cycle after the acknowledge.
- R9: When a fire event and an acknowledge occur in the same cycle, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hblank_start | input | 1 | One-cycle strobe at the start of horizontal blanking |
| line_num | input | LINE_W | Current line number |
| inactive_line | input | LINE_W | First invisible line for the current frame mode |
| reload_val | input | CNT_W | Reload value N |
| irq_enable | input | 1 | Gates the request output |
| irq_ack | input | 1 | Clears the pending flag |
| irq_pending | output | 1 | Pending flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions assume that `hblank_start` is a single-cycle pulse synchronous to `clk`, and that the other inputs are stable around the sampling edge. They do not assume that line numbers rise in order, so the stimulus gives random line numbers, random thresholds taken from the two mode values, and reload values kept small. Small reload values make fire events, and their collisions with acknowledges, frequent. All inputs change on the falling edge, so every rising edge sees settled values.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
    localparam int DEF_LINE_W = 9;
    localparam int DEF_CNT_W  = 8;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_RELOAD = 2'd1,
        ACT_DEC    = 2'd2,
        ACT_FIRE   = 2'd3
    } cnt_action_e;
endpackage

// File: rtl/line_region_check.sv
module line_region_check #(
    parameter int LINE_W = 9
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] inactive_line,
    output logic              visible
);
    always_comb begin
        visible = (line_num < inactive_line);
    end
endmodule

// File: rtl/line_irq_downcount.sv
module line_irq_downcount
    import line_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             visible,
    input  logic [CNT_W-1:0] reload_val,
    output logic             fire,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t  state_d, state_q;
    cnt_action_e act;

    always_comb begin
        state_d = state_q;
        act     = ACT_HOLD;
        if (strobe) begin
            if (!visible)                   act = ACT_RELOAD;
            else if (state_q.cnt != '0)     act = ACT_DEC;
            else                            act = ACT_FIRE;
        end
        case (act)
            ACT_RELOAD, ACT_FIRE: state_d.cnt = reload_val;
            ACT_DEC:              state_d.cnt = state_q.cnt - 1'b1;
            default:              state_d.cnt = state_q.cnt;
        endcase
        fire = (act == ACT_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count = state_q.cnt;
endmodule

// File: rtl/line_irq_pending.sv
module line_irq_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    input  logic enable,
    output logic pending,
    output logic req
);
    typedef struct packed {
        logic pend;
    } pend_state_t;

    pend_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (fire)     state_d.pend = 1'b1;
        else if (ack) state_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pending = state_q.pend;
    assign req     = state_q.pend & enable;
endmodule

// File: rtl/line_irq_counter.sv
module line_irq_counter #(
    parameter int LINE_W = 9,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] inactive_line,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              irq_enable,
    input  logic              irq_ack,
    output logic              irq_pending,
    output logic              irq_req
);
    logic             visible;
    logic             fire;
    logic [CNT_W-1:0] count_val;

    line_region_check #(.LINE_W(LINE_W)) u_region (
        .line_num      (line_num),
        .inactive_line (inactive_line),
        .visible       (visible)
    );

    line_irq_downcount #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (hblank_start),
        .visible    (visible),
        .reload_val (reload_val),
        .fire       (fire),
        .count      (count_val)
    );

    line_irq_pending u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .ack     (irq_ack),
        .enable  (irq_enable),
        .pending (irq_pending),
        .req     (irq_req)
    );
endmodule

// File: rtl/line_irq_checker.sv
module line_irq_checker #(
    parameter int LINE_W = 9,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hblank_start,
    input logic [LINE_W-1:0] line_num,
    input logic [LINE_W-1:0] inactive_line,
    input logic [CNT_W-1:0]  reload_val,
    input logic              irq_enable,
    input logic              irq_ack,
    input logic              irq_pending,
    input logic              irq_req,
    input logic [CNT_W-1:0]  count_val
);
    assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_pending && irq_enable));

    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hblank_start && !irq_ack) |=> ($stable(irq_pending) && $stable(count_val)));

    assert_inactive_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_start && line_num >= inactive_line) |=> count_val == $past(reload_val));

    assert_inactive_no_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_start && line_num >= inactive_line && !irq_pending) |=> !irq_pending);

    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_start && line_num < inactive_line && count_val != '0)
        |=> count_val == $past(count_val) - 1'b1);

    assert_fire_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank_start && line_num < inactive_line && count_val == '0)
        |=> (irq_pending && count_val == $past(reload_val)));

    assert_pending_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_ack) |=> irq_pending);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !hblank_start) |=> !irq_pending);
endmodule

bind line_irq_counter line_irq_checker #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .hblank_start  (hblank_start),
    .line_num      (line_num),
    .inactive_line (inactive_line),
    .reload_val    (reload_val),
    .irq_enable    (irq_enable),
    .irq_ack       (irq_ack),
    .irq_pending   (irq_pending),
    .irq_req       (irq_req),
    .count_val     (count_val)
);

// File: tb/test_line_irq_counter.sv
`timescale 1ns/1ps
module test_line_irq_counter;
    localparam int LW = 9;
    localparam int CW = 8;
    localparam logic [LW-1:0] TH_A = 9'd224;
    localparam logic [LW-1:0] TH_B = 9'd240;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hblank_start = 1'b0;
    logic [LW-1:0] line_num = '0;
    logic [LW-1:0] inactive_line = TH_A;
    logic [CW-1:0] reload_val = '0;
    logic          irq_enable = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_pending;
    logic          irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [CW-1:0] m_cnt = '0;
    logic          m_pend = 1'b0;

    always #2.5 clk = ~clk;

    line_irq_counter #(.LINE_W(LW), .CNT_W(CW)) i_line_irq_counter (
        .clk(clk), .rst_n(rst_n), .hblank_start(hblank_start),
        .line_num(line_num), .inactive_line(inactive_line),
        .reload_val(reload_val), .irq_enable(irq_enable), .irq_ack(irq_ack),
        .irq_pending(irq_pending), .irq_req(irq_req)
    );

    function automatic logic model_fire(logic st, logic [LW-1:0] ln,
                                        logic [LW-1:0] th, logic [CW-1:0] c);
        return st && (ln < th) && (c == '0);
    endfunction

    function automatic logic [CW-1:0] model_cnt(logic st, logic [LW-1:0] ln,
            logic [LW-1:0] th, logic [CW-1:0] rl, logic [CW-1:0] c);
        if (!st) return c;
        if (ln >= th) return rl;
        if (c != '0) return c - 1'b1;
        return rl;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic st, input logic [LW-1:0] ln, input logic [LW-1:0] th,
                        input logic [CW-1:0] rl, input logic en, input logic ak);
        logic f;
        hblank_start = st; line_num = ln; inactive_line = th;
        reload_val = rl; irq_enable = en; irq_ack = ak;
        @(posedge clk);
        f = model_fire(st, ln, th, m_cnt);
        m_cnt = model_cnt(st, ln, th, rl, m_cnt);
        if (f) m_pend = 1'b1;
        else if (ak) m_pend = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pending after reset", irq_pending, 1'b0);
        check("R1 req after reset", irq_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: counter cleared, first visible strobe fires
        step(1, 9'd10, TH_A, 8'd3, 1, 0);
        check("R1 fire on first strobe", irq_pending, 1'b1);
        check("R7 req with enable", irq_req, 1'b1);

        // R2 / R8: no strobe, no ack -> hold
        for (int i = 0; i < 5; i++) step(0, 9'd11, TH_A, 8'd3, 1, 0);
        check("R2 R8 pending held", irq_pending, 1'b1);
        step(0, 9'd11, TH_A, 8'd3, 1, 1);
        check("R8 ack clears", irq_pending, 1'b0);

        // R4 / R5: N=3 -> 3 silent strobes, 4th fires
        for (int i = 0; i < 3; i++) begin
            step(1, 9'(20 + i), TH_A, 8'd3, 1, 0);
            check("R4 decrement no fire", irq_pending, 1'b0);
        end
        step(1, 9'd23, TH_A, 8'd3, 1, 0);
        check("R5 fire after N+1", irq_pending, 1'b1);

        // R9: ack coincides with fire
        for (int i = 0; i < 3; i++) step(1, 9'(30 + i), TH_A, 8'd3, 1, 1);
        check("R4 ack cleared while counting", irq_pending, 1'b0);
        step(1, 9'd33, TH_A, 8'd3, 1, 1);
        check("R9 fire beats ack", irq_pending, 1'b1);

        // R7: enable low gates request
        step(0, 9'd34, TH_A, 8'd3, 0, 0);
        check("R7 req gated", irq_req, 1'b0);
        check("R7 pending kept", irq_pending, 1'b1);
        step(0, 9'd34, TH_A, 8'd3, 1, 1);

        // R3: line equal to threshold is invisible, reload 2
        step(1, TH_A, TH_A, 8'd2, 1, 0);
        check("R3 boundary no fire", irq_pending, 1'b0);
        step(1, 9'd0, TH_A, 8'd2, 1, 0);
        step(1, 9'd1, TH_A, 8'd2, 1, 0);
        check("R3 reloaded count still running", irq_pending, 1'b0);
        step(1, 9'd2, TH_A, 8'd2, 1, 0);
        check("R3 fire after reload+1", irq_pending, 1'b1);
        step(0, 9'd2, TH_A, 8'd2, 1, 1);

        // R6: line 230 invisible under 224, visible under 240
        step(1, 9'd230, TH_A, 8'd0, 1, 0);
        check("R6 line 230 invisible with low threshold", irq_pending, 1'b0);
        step(1, 9'd230, TH_B, 8'd0, 1, 0);
        check("R6 line 230 visible with high threshold", irq_pending, 1'b1);
        step(0, 9'd0, TH_B, 8'd0, 1, 1);

        // Random mix checked against model (R5 R7 R8)
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic st, en, ak;
            logic [LW-1:0] ln, th;
            logic [CW-1:0] rl;
            st = ($urandom % 3) == 0;
            en = ($urandom % 4) != 0;
            ak = ($urandom % 5) == 0;
            ln = 9'($urandom % 262);
            th = ($urandom % 2) ? TH_A : TH_B;
            rl = 8'($urandom % 6);
            step(st, ln, th, rl, en, ak);
            check("R5 R8 random pending", irq_pending, m_pend);
            check("R7 random req", irq_req, m_pend & en);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule